// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a single-clock synchronous SRAM whose read and write cycles can alternate on every clock with no idle cycle between them. Address and control are captured on the rising edge. Read data flows straight from the array onto the bus in the cycle that follows. Write data is taken one clock after its address, so a read followed by a write, or a write followed by a read, never fight over the bus.

A cycle starts when the burst-step strobe is low. The block then loads the external address and works out the cycle type from three chip selects and the write strobe. While the burst-step strobe is high, a 2-bit internal counter moves the low address bits, in either linear or interleaved order, and the current cycle type carries on. Byte lanes can be masked on writes. Reads can run as dummy reads with the bus left undriven. A hold input freezes the whole block, and a sleep input forces the bus driver off.

The data bus is brought out as a pad-side triple: `dq_i` carries data in, `dq_o` carries data out, and `bus_drive` is the enable of the output driver.

Top module: `zbt_ft_sram`

## Requirements
- R1: While reset is high and on the first cycle after it, the block is deselected and `bus_drive` is 0.
- R2: On an edge where `hold` is 1, every synchronous input is ignored and all internal state is kept: no cycle begins, no burst step occurs, no write data is taken, and the output stays as it was.
- R3: With `burst_step` low, `addr` is loaded and a cycle begins. The cycle is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A selected cycle is a read if `write_n`=1 and a write if `write_n`=0. Any other chip-select combination gives a deselect cycle.
- R4: In the cycle after a read edge, if `drive_en_n`=0 and `sleep`=0, `bus_drive` is 1 and `dq_o` holds the word at the cycle's effective address. `drive_en_n` acts on the driver without waiting for a clock.
- R5: Write data on `dq_i` is sampled at the next enabled edge after the write's address edge. Lane i, which is bits [i*LANE_W +: LANE_W], is written only if `lane_we_n[i]` was 0 at the address edge.
- R6: A write cycle with every `lane_we_n` bit at 1 changes no location, but its burst still advances.
- R7: A read with `drive_en_n`=1 is a dummy read: its address and burst advance, and `bus_drive` stays 0.
- R8: With `burst_ilv`=0 latched at the begin edge, the low two address bits on the k-th step are (base + k) mod 4. The upper bits never change inside a burst.
- R9: With `burst_ilv`=1 latched at the begin edge, the low two address bits on the k-th step are base XOR k.
- R10: With `burst_step` high, the current read, write or deselect continues whatever the chip selects show. A continue after a deselect stays deselected.
- R11: Reads and writes may alternate on every clock. A read of a location in the cycle right after its write data is taken returns the new lanes merged with the unwritten old lanes. `bus_drive` is never 1 on an edge that takes write data.
- R12: `sleep`=1 forces `bus_drive` to 0 at once, whatever the cycle type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | High suspends the clock: inputs ignored, state kept |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| burst_step | input | 1 | Low: load address and begin; high: step burst |
| write_n | input | 1 | Low selects write, high selects read |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| drive_en_n | input | 1 | Output driver enable, active low, asynchronous |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Forces the output driver off |
| addr | input | ADDR_W | External word address |
| dq_i | input | LANES*LANE_W | Bus data seen at the pad |
| dq_o | output | LANES*LANE_W | Read data toward the pad |
| bus_drive | output | 1 | Pad driver enable |

## Verification
The bench builds the block at its defaults: 6 address bits (64 words) and four 9-bit lanes. With these values the whole array can be filled and then read back through short bursts. Bursts start at every low-bit offset, so both orders wrap inside a four-word group. The four lanes give enough mask patterns to show partial merges, and read-after-write happens in the same clock as the write commit.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // low address bits for burst step cnt from base
    function automatic logic [BURST_W-1:0] burst_lsb(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               ilv
    );
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              step,
    input  logic              sel,
    input  logic              write_n,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr_i,
    output op_e               op_o,
    output logic [ADDR_W-1:0] ea_o
);

    op_e                op_q;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               ilv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_DESEL;
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else if (ce) begin
            if (!step) begin
                base_q <= addr_i;
                cnt_q  <= '0;
                ilv_q  <= ilv;
                if (sel) op_q <= write_n ? OP_READ : OP_WRITE;
                else     op_q <= OP_DESEL;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign op_o = op_q;
    assign ea_o = {base_q[ADDR_W-1:BURST_W], burst_lsb(base_q[BURST_W-1:0], cnt_q, ilv_q)};

    // R2
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(op_o) && $stable(ea_o)));

    // R10
    desel_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && step && op_o == OP_DESEL) |=> (op_o == OP_DESEL));

    // R8
    burst_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && step) |=> (ea_o[ADDR_W-1:BURST_W] == $past(ea_o[ADDR_W-1:BURST_W])));

endmodule

// File: rtl/zbt_wr_lag.sv
module zbt_wr_lag
    import zbt_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [LANES-1:0] lane_we_n,
    input  op_e              op_i,
    output logic [LANES-1:0] lane_wr_o
);

    logic [LANES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)     mask_q <= '1;
        else if (ce) mask_q <= lane_we_n;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_wr_o[g] = ce && (op_i == OP_WRITE) && !mask_q[g];
    end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_wr,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_wr[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hold,
    input  logic                    cs_a_n,
    input  logic                    cs_b,
    input  logic                    cs_c_n,
    input  logic                    burst_step,
    input  logic                    write_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    drive_en_n,
    input  logic                    burst_ilv,
    input  logic                    sleep,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    bus_drive
);

    localparam int DATA_W = LANES * LANE_W;

    logic              ce;
    logic              sel;
    op_e               op;
    logic [ADDR_W-1:0] ea;
    logic [LANES-1:0]  lane_wr;
    logic [DATA_W-1:0] rdata;

    assign ce  = !hold;
    assign sel = !cs_a_n && cs_b && !cs_c_n;

    zbt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .step    (burst_step),
        .sel     (sel),
        .write_n (write_n),
        .ilv     (burst_ilv),
        .addr_i  (addr),
        .op_o    (op),
        .ea_o    (ea)
    );

    zbt_wr_lag #(.LANES(LANES)) u_wr_lag (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .lane_we_n (lane_we_n),
        .op_i      (op),
        .lane_wr_o (lane_wr)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .lane_wr (lane_wr),
        .waddr   (ea),
        .wdata   (dq_i),
        .raddr   (ea),
        .rdata   (rdata)
    );

    assign dq_o      = rdata;
    assign bus_drive = (op == OP_READ) && !drive_en_n && !sleep;

    // R11
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        (|lane_wr) |-> !bus_drive);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !bus_drive);

endmodule

// File: tb/tb_zbt_ft_sram.sv
module tb_zbt_ft_sram;

    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold = 1'b0;
    logic cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
    logic burst_step = 1'b0, write_n = 1'b1;
    logic [LN-1:0] lane_we_n = '1;
    logic drive_en_n = 1'b0, burst_ilv = 1'b0, sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic bus_drive;

    always #2 clk = ~clk;

    zbt_ft_sram dut (
        .clk(clk), .rst(rst), .hold(hold), .cs_a_n(cs_a_n), .cs_b(cs_b),
        .cs_c_n(cs_c_n), .burst_step(burst_step), .write_n(write_n),
        .lane_we_n(lane_we_n), .drive_en_n(drive_en_n), .burst_ilv(burst_ilv),
        .sleep(sleep), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .bus_drive(bus_drive)
    );

    int checks = 0;
    int errors = 0;
    int salt = 1;

    // behavioural reference state
    logic [DW-1:0] m_mem [64];
    int m_op = 0;              // 0 deselect, 1 read, 2 write
    int m_base = 0, m_cnt = 0, m_ilv = 0, m_eff = 0;
    int m_pend = 0, m_paddr = 0;
    logic [LN-1:0] m_pbe = '0;

    function automatic logic [DW-1:0] mix(int a, int s);
        logic [11:0] s12;
        logic [5:0]  a6;
        s12 = 12'(s * 37 + 5);
        a6  = 6'(a);
        return {s12, a6, ~s12, a6};
    endfunction

    task automatic check(string tag, logic got_oe, logic [DW-1:0] got_d);
        logic exp_oe;
        exp_oe = (m_op == 1) && !drive_en_n && !sleep;
        checks++;
        if (got_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s bus_drive actual %0b expected %0b", tag, got_oe, exp_oe);
        end else if (exp_oe && got_d !== m_mem[m_eff]) begin
            errors++;
            $display("FAIL %s dq_o actual %h expected %h", tag, got_d, m_mem[m_eff]);
        end
    endtask

    task automatic tick(string tag);
        dq_i = mix(m_paddr, salt);
        @(posedge clk);
        if (!hold) begin
            if (m_pend != 0)
                for (int l = 0; l < LN; l++)
                    if (m_pbe[l]) m_mem[m_paddr][l*LW +: LW] = dq_i[l*LW +: LW];
            m_pend = 0;
            if (!burst_step) begin
                m_base = int'(addr);
                m_cnt  = 0;
                m_ilv  = int'(burst_ilv);
                if (!cs_a_n && cs_b && !cs_c_n) m_op = write_n ? 1 : 2;
                else                             m_op = 0;
            end else begin
                m_cnt = (m_cnt + 1) % 4;
            end
            m_eff = (m_base & ~3) | (m_ilv != 0 ? ((m_base ^ m_cnt) & 3) : ((m_base + m_cnt) & 3));
            if (m_op == 2 && lane_we_n != '1) begin
                m_pend  = 1;
                m_paddr = m_eff;
                m_pbe   = ~lane_we_n;
            end
        end
        #1;
        check(tag, bus_drive, dq_o);
        salt++;
    endtask

    task automatic sel_on();
        cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
    endtask

    task automatic begin_cyc(int a, logic wn, logic [LN-1:0] be, logic ilv, string tag);
        sel_on();
        burst_step = 1'b0; write_n = wn; lane_we_n = be; addr = AW'(a); burst_ilv = ilv;
        tick(tag);
    endtask

    task automatic cont_cyc(logic [LN-1:0] be, string tag);
        burst_step = 1'b1; lane_we_n = be;
        tick(tag);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", bus_drive, dq_o);
        rst = 1'b0;
        cs_a_n = 1'b1; burst_step = 1'b1;
        tick("R1");

        // R5 R8: fill array with linear write bursts, all lanes
        for (int g = 0; g < 16; g++) begin
            begin_cyc(g * 4, 1'b0, '0, 1'b0, "R5");
            for (int k = 0; k < 3; k++) cont_cyc('0, "R8");
        end
        // end with a deselect so the last data is taken
        cs_a_n = 1'b1; burst_step = 1'b0;
        tick("R3");

        // R4 R8: linear read wrap from offset 2
        begin_cyc(6, 1'b1, '1, 1'b0, "R4");
        for (int k = 0; k < 3; k++) cont_cyc('1, "R8");

        // R9: interleaved reads from every offset
        for (int b = 0; b < 4; b++) begin
            begin_cyc(36 + b, 1'b1, '1, 1'b1, "R9");
            for (int k = 0; k < 3; k++) cont_cyc('1, "R9");
        end

        // R5 R11: masked write, then read same word next cycle (merge)
        begin_cyc(20, 1'b0, 4'b1010, 1'b0, "R5");
        begin_cyc(20, 1'b1, '1, 1'b0, "R11");
        begin_cyc(22, 1'b0, 4'b0110, 1'b0, "R5");
        begin_cyc(22, 1'b1, '1, 1'b0, "R11");

        // R6: write abort burst leaves data, burst still advances
        begin_cyc(24, 1'b0, '1, 1'b0, "R6");
        cont_cyc('1, "R6");
        cont_cyc(4'b1110, "R6");   // third word (26) lane 0 written
        cont_cyc('1, "R6");
        begin_cyc(24, 1'b1, '1, 1'b0, "R6");
        for (int k = 0; k < 3; k++) cont_cyc('1, "R6");

        // R7: dummy read then driver enabled mid-burst
        drive_en_n = 1'b1;
        begin_cyc(28, 1'b1, '1, 1'b0, "R7");
        cont_cyc('1, "R7");
        drive_en_n = 1'b0;
        #1;
        check("R4", bus_drive, dq_o);
        cont_cyc('1, "R4");

        // R3: each enable alone deselects
        begin_cyc(8, 1'b1, '1, 1'b0, "R3");
        cs_a_n = 1'b1; burst_step = 1'b0; tick("R3");
        sel_on(); cs_b = 1'b0; tick("R3");
        sel_on(); cs_c_n = 1'b1; tick("R3");
        // R10: continue after deselect stays deselected even with select on
        sel_on(); burst_step = 1'b1; tick("R10");
        tick("R10");
        // R10: read burst continues with selects off
        begin_cyc(12, 1'b1, '1, 1'b0, "R10");
        cs_a_n = 1'b1; cs_b = 1'b0; burst_step = 1'b1; tick("R10");
        tick("R10");

        // R11: alternate write/read every clock
        for (int i = 0; i < 8; i++) begin
            begin_cyc(40 + i, 1'b0, 4'(i), 1'b0, "R11");
            begin_cyc(40 + i, 1'b1, '1, 1'b0, "R11");
        end
        begin_cyc(48, 1'b1, '1, 1'b0, "R11");
        begin_cyc(49, 1'b0, '0, 1'b0, "R11");
        begin_cyc(50, 1'b1, '1, 1'b0, "R11");
        begin_cyc(49, 1'b1, '1, 1'b0, "R11");

        // R2: hold during read burst and during a write data phase
        begin_cyc(16, 1'b1, '1, 1'b0, "R2");
        hold = 1'b1;
        begin_cyc(60, 1'b0, '0, 1'b1, "R2");
        cont_cyc('0, "R2");
        hold = 1'b0;
        cont_cyc('1, "R2");
        begin_cyc(52, 1'b0, 4'b0011, 1'b0, "R2");
        hold = 1'b1;
        cont_cyc('1, "R2");
        tick("R2");
        hold = 1'b0;
        begin_cyc(52, 1'b1, '1, 1'b0, "R2");
        begin_cyc(60, 1'b1, '1, 1'b0, "R2");

        // R12: sleep forces driver off
        begin_cyc(4, 1'b1, '1, 1'b0, "R12");
        sleep = 1'b1;
        #1;
        check("R12", bus_drive, dq_o);
        cont_cyc('1, "R12");
        sleep = 1'b0;
        cont_cyc('1, "R12");

        cs_a_n = 1'b1; burst_step = 1'b0;
        tick("R3");
        finish_run();
    end

endmodule